// File: doc/BRIEF.md
# Indirect-Indexed Codec Control Register File

This block is the host-facing control register file of an audio codec. A host reaches it through a 64-byte window. The window holds sixteen 32-bit direct registers, and the block selects one of them from the word address, which is the byte address shifted right by two. Direct register 0 acts as an index pointer: its low five bits choose one of thirty-two 8-bit indirect registers. Direct register 1 does not store a value of its own. It is a data port that reads and writes whichever indirect register the pointer currently selects.

Several indirect slots have special behaviour. Slot 3 accepts writes but always reads as zero. Slots 11 and 25 ignore writes. Slot 25 carries a fixed chip version code. Slot 12 merges one writable bit with fixed codec-version bits.

Direct register 2 ignores writes. Direct register 4 is the control register. When a write to it has bit 0 set, the whole register state returns to its reset values. The control register itself then takes the written value masked to seven bits. The interrupt output exists for integration only and never asserts.

Top module: `codec_regfile`

## Requirements
- R1: After the active-low reset, every direct register reads 0. Every indirect slot reads 0, except slot 12, which reads 0x8A, and slot 25, which reads 0xA0.
- R2: Direct register 0 stores all 32 written bits. Its bits [4:0] select the indirect slot that the data port (word address 1) reaches.
- R3: A write to word address 1 stores wdata[7:0] into the selected indirect slot. A read of word address 1 returns the selected slot zero-extended to 32 bits.
- R4: Indirect slot 3 reads 0 through the data port, whatever was written to it.
- R5: Writes to indirect slots 11 and 25 have no effect. Slot 11 keeps reading 0 and slot 25 keeps reading 0xA0.
- R6: A write to indirect slot 12 keeps only bit 6 of the written byte. The slot then reads (wdata & 0x40) | 0x8A.
- R7: Writes to direct register 2 are ignored, and it always reads 0.
- R8: A write to direct register 4 stores wdata[6:0], zero-extended. If wdata[0] is 1, the same write returns all other direct registers and all indirect slots to their R1 values. After that write, the control register holds the written value masked to seven bits.
- R9: Direct registers 3 and 5 to 15 store and return all 32 written bits.
- R10: The interrupt output is 0 at all times.
- R11: While sel is 0, rdata is 0 and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Access select |
| wr_en | input | 1 | Write enable, used while sel is 1 |
| addr | input | 4 | Word address (byte address >> 2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from current state |
| irq | output | 1 | Interrupt request, held low |

## Verification
A write with sel and wr_en high takes effect at the next rising clock edge. This includes the soft reset and the masked control value, which land together at that one edge. Read data is combinational, so a read is valid in the same cycle its address is presented. The bench therefore drives every input on the falling edge. For a read, it samples rdata one nanosecond later, well before the next rising edge. Any readback after a write takes place at least one full edge after that write, so each expected value reflects exactly one register update.

// File: rtl/codec_rf_pkg.sv
// Package: shared sizes, special register indices and reset values for the
// codec control register file. Assumes the index layout is fixed by software.
package codec_rf_pkg;
    parameter int DATA_W   = 32;
    parameter int NUM_DIR  = 16;
    parameter int IND_W    = 8;
    parameter int NUM_IND  = 32;
    parameter int CTRL_W   = 7;

    // Direct register roles
    parameter int DIR_INDEX = 0;
    parameter int DIR_PORT  = 1;
    parameter int DIR_RO    = 2;
    parameter int DIR_CTRL  = 4;

    // Indirect slot roles
    parameter int IND_WONLY = 3;
    parameter int IND_RO_A  = 11;
    parameter int IND_MERGE = 12;
    parameter int IND_RO_B  = 25;

    parameter logic [7:0] CODEC_VER = 8'h8A;
    parameter logic [7:0] CHIP_VER  = 8'hA0;
    parameter logic [7:0] MERGE_KEEP = 8'h40;

    // Reset value of an indirect slot
    function automatic logic [IND_W-1:0] ind_rst_val(input int j);
        if (j == IND_MERGE) return IND_W'(CODEC_VER);
        if (j == IND_RO_B)  return IND_W'(CHIP_VER);
        return '0;
    endfunction
endpackage

// File: rtl/codec_dir_bank.sv
// Direct register bank. Holds the word-addressed 32-bit registers.
// Assumes: the data-port and read-only slots hold no storage; the control
// slot stores a masked write even when that write triggers soft reset.
module codec_dir_bank
    import codec_rf_pkg::*;
#(
    parameter int N      = NUM_DIR,
    parameter int W      = DATA_W,
    parameter int CW     = CTRL_W,
    localparam int AW    = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          soft_rst,
    output logic [W-1:0]  dir_q [N]
);
    for (genvar i = 0; i < N; i++) begin : g_dir
        if (i == DIR_PORT || i == DIR_RO) begin : g_none
            // No storage behind the data port or the read-only slot
            assign dir_q[i] = '0;
        end else if (i == DIR_CTRL) begin : g_ctrl
            logic [W-1:0] q;
            // Control register: masked store, wins over the soft reset it causes
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_stb && waddr == AW'(i))
                    q <= {{(W-CW){1'b0}}, wdata[CW-1:0]};
            end
            assign dir_q[i] = q;
        end else begin : g_plain
            logic [W-1:0] q;
            // Plain register: full-width store, cleared by either reset
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)
                    q <= '0;
                else if (wr_stb && waddr == AW'(i))
                    q <= wdata;
            end
            assign dir_q[i] = q;
        end
    end
endmodule

// File: rtl/codec_ind_bank.sv
// Indirect register bank reached through the data port.
// Assumes: write strobe is already qualified with the data-port address;
// read-only slots are constants equal to their reset values.
module codec_ind_bank
    import codec_rf_pkg::*;
#(
    parameter int N      = NUM_IND,
    parameter int W      = IND_W,
    localparam int IW    = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    input  logic          soft_rst,
    output logic [W-1:0]  ind_q [N]
);
    for (genvar j = 0; j < N; j++) begin : g_ind
        if (j == IND_RO_A || j == IND_RO_B) begin : g_ro
            // Read-only slot: fixed value
            assign ind_q[j] = ind_rst_val(j);
        end else if (j == IND_MERGE) begin : g_merge
            logic [W-1:0] q;
            // Merge slot: one writable bit, rest forced to the version code
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)
                    q <= ind_rst_val(j);
                else if (wr_stb && idx == IW'(j))
                    q <= (wdata & W'(MERGE_KEEP)) | W'(CODEC_VER);
            end
            assign ind_q[j] = q;
        end else begin : g_rw
            logic [W-1:0] q;
            // Ordinary slot: byte store
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)
                    q <= ind_rst_val(j);
                else if (wr_stb && idx == IW'(j))
                    q <= wdata;
            end
            assign ind_q[j] = q;
        end
    end
endmodule

// File: rtl/codec_rd_mux.sv
// Read mux: picks a direct register, or the selected indirect slot for the
// data port. Assumes the write-only slot must never leak its contents.
module codec_rd_mux
    import codec_rf_pkg::*;
#(
    parameter int ND     = NUM_DIR,
    parameter int NI     = NUM_IND,
    parameter int W      = DATA_W,
    parameter int IWD    = IND_W,
    localparam int AW    = $clog2(ND),
    localparam int IW    = $clog2(NI)
) (
    input  logic          sel,
    input  logic [AW-1:0] addr,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  dir_q [ND],
    input  logic [IWD-1:0] ind_q [NI],
    output logic [W-1:0]  rdata
);
    // Combinational read selection
    always_comb begin
        rdata = '0;
        if (sel) begin
            if (addr == AW'(DIR_PORT)) begin
                if (idx != IW'(IND_WONLY))
                    rdata = {{(W-IWD){1'b0}}, ind_q[idx]};
            end else begin
                rdata = dir_q[addr];
            end
        end
    end
endmodule

// File: rtl/codec_regfile.sv
// Top: codec control register file. Decodes the host access, raises the
// soft reset from the control register, and ties the interrupt low.
// Assumes single-cycle writes and combinational reads.
module codec_regfile
    import codec_rf_pkg::*;
#(
    parameter int ND     = NUM_DIR,
    parameter int NI     = NUM_IND,
    parameter int W      = DATA_W,
    parameter int IWD    = IND_W,
    localparam int AW    = $clog2(ND),
    localparam int IW    = $clog2(NI)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          irq
);
    logic           wr_stb;
    logic           soft_rst;
    logic           port_wr;
    logic [IW-1:0]  idx;
    logic [W-1:0]   dir_q [ND];
    logic [IWD-1:0] ind_q [NI];

    assign wr_stb   = sel && wr_en;
    assign soft_rst = wr_stb && addr == AW'(DIR_CTRL) && wdata[0];
    assign port_wr  = wr_stb && addr == AW'(DIR_PORT);
    assign idx      = dir_q[DIR_INDEX][IW-1:0];
    assign irq      = 1'b0;

    codec_dir_bank #(.N(ND), .W(W), .CW(CTRL_W)) u_dir (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .waddr(addr),
        .wdata(wdata), .soft_rst(soft_rst), .dir_q(dir_q)
    );

    codec_ind_bank #(.N(NI), .W(IWD)) u_ind (
        .clk(clk), .rst_n(rst_n), .wr_stb(port_wr), .idx(idx),
        .wdata(wdata[IWD-1:0]), .soft_rst(soft_rst), .ind_q(ind_q)
    );

    codec_rd_mux #(.ND(ND), .NI(NI), .W(W), .IWD(IWD)) u_rd (
        .sel(sel), .addr(addr), .idx(idx), .dir_q(dir_q),
        .ind_q(ind_q), .rdata(rdata)
    );
endmodule

// File: rtl/codec_regfile_chk.sv
// Checker for codec_regfile. Keeps its own shadow of the index pointer,
// built only from port activity, and checks read values against it.
module codec_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic        wr_en,
    input logic [3:0]  addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        irq
);
    logic [4:0] sh_idx;
    logic       seen_clk;

    // Shadow index pointer from host writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_idx <= '0;
        else if (sel && wr_en && addr == 4'd0)
            sh_idx <= wdata[4:0];
        else if (sel && wr_en && addr == 4'd4 && wdata[0])
            sh_idx <= '0;
    end

    // Marks that at least one edge has passed since time zero
    always_ff @(posedge clk) seen_clk <= 1'b1;

    // R10
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n) irq == 1'b0);

    // R7
    dir_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && addr == 4'd2) |-> rdata == 32'd0);

    // R4
    wonly_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_clk)
        (sel && addr == 4'd1 && sh_idx == 5'd3) |-> rdata == 32'd0);

    // R5
    chipver_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_clk)
        (sel && addr == 4'd1 && sh_idx == 5'd25) |-> rdata == 32'h0000_00A0);

    // R6
    merge_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_clk)
        (sel && addr == 4'd1 && sh_idx == 5'd12) |-> (rdata & 32'hFFFF_FFBF) == 32'h0000_008A);

    // R3
    port_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && addr == 4'd1) |-> rdata[31:8] == 24'd0);

    // R8
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && addr == 4'd4) |=>
        (!(sel && addr == 4'd4) || rdata == {25'd0, $past(wdata[6:0])}));

    // R11
    idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n) !sel |-> rdata == 32'd0);
endmodule

bind codec_regfile codec_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
);

// File: tb/sim_codec_regfile.sv
// Directed bench for codec_regfile: one task per scenario, each self-checking.
module sim_codec_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    codec_regfile u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write: driven on the falling edge, lands at the next rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
    endtask

    // Read: combinational, sampled 1 ns after the falling edge
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; addr = a;
        #1 d = rdata;
        check("R10 irq", {31'd0, irq}, 32'd0);
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic rd_ind(input logic [4:0] j, output logic [31:0] d);
        wr(4'd0, {27'd0, j});
        rd(4'd1, d);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), v);
            if (i != 1) check($sformatf("R1 dir%0d", i), v, 32'd0);
        end
        for (int j = 0; j < 32; j++) begin
            rd_ind(5'(j), v);
            check($sformatf("R1 ind%0d", j), v,
                  (j == 12) ? 32'h8A : (j == 25) ? 32'hA0 : 32'd0);
        end
    endtask

    task automatic t_direct();
        logic [31:0] v;
        wr(4'd5, 32'hDEAD_BEEF); wr(4'd15, 32'h1234_5678); wr(4'd3, 32'hFFFF_0001);
        rd(4'd5, v);  check("R9 dir5", v, 32'hDEAD_BEEF);
        rd(4'd15, v); check("R9 dir15", v, 32'h1234_5678);
        rd(4'd3, v);  check("R9 dir3", v, 32'hFFFF_0001);
        wr(4'd0, 32'hA5A5_A5E7);
        rd(4'd0, v);  check("R2 dir0 full", v, 32'hA5A5_A5E7);
    endtask

    task automatic t_index();
        logic [31:0] v;
        wr(4'd0, 32'hFFFF_FFE7);          // index 7 from low five bits
        wr(4'd1, 32'h1234_56C3);
        rd(4'd1, v);  check("R3 port zext", v, 32'h0000_00C3);
        wr(4'd0, 32'd8);
        wr(4'd1, 32'h0000_0011);
        rd_ind(5'd7, v); check("R2 idx7 kept", v, 32'h0000_00C3);
        rd_ind(5'd8, v); check("R3 idx8", v, 32'h0000_0011);
    endtask

    task automatic t_special();
        logic [31:0] v;
        wr(4'd0, 32'd3); wr(4'd1, 32'h55);
        rd(4'd1, v); check("R4 wonly", v, 32'd0);
        wr(4'd0, 32'd11); wr(4'd1, 32'hFF);
        rd(4'd1, v); check("R5 slot11", v, 32'd0);
        wr(4'd0, 32'd25); wr(4'd1, 32'h00);
        rd(4'd1, v); check("R5 slot25", v, 32'hA0);
        wr(4'd0, 32'd12); wr(4'd1, 32'hFF);
        rd(4'd1, v); check("R6 merge ff", v, 32'hCA);
        wr(4'd1, 32'h00);
        rd(4'd1, v); check("R6 merge 00", v, 32'h8A);
        wr(4'd1, 32'hFF);
        wr(4'd2, 32'hCAFE_F00D);
        rd(4'd2, v); check("R7 dir2", v, 32'd0);
    endtask

    task automatic t_idle();
        logic [31:0] v;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b1; addr = 4'd5; wdata = 32'h0;
        #1 check("R11 idle rdata", rdata, 32'd0);
        @(negedge clk); wr_en = 1'b0;
        rd(4'd5, v); check("R11 no write", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(4'd4, 32'hFFFF_FFFE);
        rd(4'd4, v); check("R8 mask", v, 32'h7E);
        rd(4'd5, v); check("R8 no reset", v, 32'hDEAD_BEEF);
        wr(4'd0, 32'd12);
        wr(4'd4, 32'h0000_0081);
        rd(4'd4, v); check("R8 ctrl after reset", v, 32'h01);
        rd(4'd0, v); check("R8 dir0 cleared", v, 32'd0);
        rd(4'd5, v); check("R8 dir5 cleared", v, 32'd0);
        rd_ind(5'd7, v);  check("R8 ind7 cleared", v, 32'd0);
        rd_ind(5'd12, v); check("R8 ind12 restored", v, 32'h8A);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_index();
        t_special();
        t_idle();
        t_ctrl();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule